// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory through a single request/acknowledge port that can read and write. A translation starts with one cycle of `req_valid`. The walker reads the directory entry. When that entry does not map a 4 MiB page, it also reads the table entry. It merges the user and write permission bits, checks the access against them, and writes an entry back when its accessed or dirty flag has to be set. It ends with a one-cycle `done` pulse that carries either a physical address or a fault with its error code.

The control inputs are captured together with the request and stay fixed for the whole walk. They are: the paging enable, supervisor write-protect, large-page enable, directory base and address-20 mask. A debug request runs the same walk, but it skips the permission checks, never writes memory and never faults. A missing entry returns all ones instead.

Entry bit positions: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 7 page size.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, the result is the linear address unchanged, with no fault and no memory access.
- R2: The directory entry address is ((base & ~0xFFF) + ((lin >> 20) & ~3)) & a20_mask.
- R3: The table entry address is ((dir_entry & ~0xFFF) + ((lin >> 10) & 0xFFC)) & a20_mask.
- R4: A 4 MiB page is used only when directory bit 7 and the large-page enable are both set. Otherwise the table entry is read, even if bit 7 is set.
- R5: For 4 KiB pages, the effective user and writable bits are the AND of the two entries. For large pages, only the directory entry's bits count.
- R6: A user access faults when the effective user bit is 0, or when it is a write and the effective writable bit is 0.
- R7: A supervisor write faults only when write-protect is set, the effective user bit is 1 and the effective writable bit is 0. Supervisor reads never fault on permissions.
- R8: A non-present directory or table entry gives a fault with error bit 0 clear. In debug mode it gives physical address 0xFFFFFFFF with no fault.
- R9: Writeback rules:
  - For a 4 KiB page, the directory entry is written back with bit 5 set only when bit 5 was clear.
  - The final entry (the table entry, or the directory entry for a large page) is written back with bit 5 set, and with bit 6 set on a write, only when bit 5 was clear or a write finds bit 6 clear.
  - No other writes occur.
- R10: The physical address is (frame & a20_mask) plus the in-page offset. The frame is bits 31:12 of the table entry for a 4 KiB page, or bits 31:22 of the directory entry for a 4 MiB page.
- R11: The fault error code has bit 0 set for a protection fault (clear for not-present), bit 1 equal to the write flag and bit 2 equal to the user flag.
- R12: The walker handles one request at a time. `busy` is high from acceptance to completion, requests seen while busy are ignored, `done` is a one-cycle pulse, and a memory request is held with a stable address until acknowledged.
- R13: A debug walk never issues a memory write and never reports a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (ignored while busy) |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| req_debug | input | 1 | Inspection walk: no writes, no faults |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write-protect |
| cfg_large | input | 1 | Large-page enable |
| cfg_root | input | 32 | Directory base address |
| cfg_a20 | input | 32 | Address-20 wrap mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Translation faulted |
| done_err | output | 3 | Fault error code |
| done_phys | output | 32 | Physical address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong stored entry or a wrong state shows up at the ports within a single walk. It appears as a wrong address on the memory port in the cycle the request is raised, as an extra or missing write before `done`, or as a wrong physical address or error code on the `done` cycle. The bench records every memory address and every write of each walk and compares them, together with the result and the final memory words, against its own model of the walk. Random entries reach all the permission, presence and writeback combinations, including directory and table entries that fall on the same memory word.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  input  logic        req_debug,
  input  logic        cfg_paging,
  input  logic        cfg_wp,
  input  logic        cfg_large,
  input  logic [31:0] cfg_root,
  input  logic [31:0] cfg_a20,
  output logic        busy,
  output logic        done,
  output logic        done_fault,
  output logic [2:0]  done_err,
  output logic [31:0] done_phys,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_CHK_DIR, S_WB_DIR, S_RD_TBL, S_CHK_TBL, S_WB_TBL, S_DONE
  } st_t;

  st_t st;
  logic [31:0] lin_q, root_q, a20_q, pde_q, pte_q, phys_q;
  logic        wr_q, usr_q, dbg_q, pg_q, wp_q, large_q, fault_q;
  logic [2:0]  err_q;

  logic [31:0] dir_addr, tbl_addr, big_phys, small_phys, dir_upd, tbl_upd;
  logic        lg, eff_u, eff_rw, perm_bad, dir_wb, tbl_wb;

  assign dir_addr   = ((root_q & ~32'hFFF) + ((lin_q >> 20) & ~32'h3)) & a20_q;
  assign tbl_addr   = ((pde_q & ~32'hFFF) + ((lin_q >> 10) & 32'hFFC)) & a20_q;
  assign lg         = pde_q[B_PS] & large_q;
  assign eff_u      = lg ? pde_q[B_US] : (pde_q[B_US] & pte_q[B_US]);
  assign eff_rw     = lg ? pde_q[B_RW] : (pde_q[B_RW] & pte_q[B_RW]);
  assign perm_bad   = usr_q ? (!eff_u || (wr_q && !eff_rw))
                            : (wp_q && eff_u && wr_q && !eff_rw);
  assign big_phys   = (pde_q & a20_q & 32'hFFC0_0000) | (lin_q & 32'h003F_FFFF);
  assign small_phys = (pte_q & a20_q & 32'hFFFF_F000) | (lin_q & 32'h0000_0FFF);
  assign dir_upd    = pde_q | (32'd1 << B_A) | ((lg && wr_q) ? (32'd1 << B_D) : 32'd0);
  assign tbl_upd    = pte_q | (32'd1 << B_A) | (wr_q ? (32'd1 << B_D) : 32'd0);
  assign dir_wb     = !pde_q[B_A] || (lg && wr_q && !pde_q[B_D]);
  assign tbl_wb     = !pte_q[B_A] || (wr_q && !pte_q[B_D]);

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign done_fault = fault_q;
  assign done_err   = err_q;
  assign done_phys  = phys_q;
  assign mem_req    = (st == S_RD_DIR) || (st == S_WB_DIR) || (st == S_RD_TBL) || (st == S_WB_TBL);
  assign mem_we     = (st == S_WB_DIR) || (st == S_WB_TBL);
  assign mem_addr   = ((st == S_RD_DIR) || (st == S_WB_DIR)) ? dir_addr : tbl_addr;
  assign mem_wdata  = (st == S_WB_DIR) ? pde_q : pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lin_q <= '0; root_q <= '0; a20_q <= '0; pde_q <= '0; pte_q <= '0; phys_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; dbg_q <= 1'b0; pg_q <= 1'b0; wp_q <= 1'b0;
      large_q <= 1'b0; fault_q <= 1'b0; err_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q <= req_lin; wr_q <= req_write; usr_q <= req_user; dbg_q <= req_debug;
          pg_q <= cfg_paging; wp_q <= cfg_wp; large_q <= cfg_large;
          root_q <= cfg_root; a20_q <= cfg_a20;
          fault_q <= 1'b0; err_q <= '0;
          if (!cfg_paging) begin
            phys_q <= req_lin;
            st <= S_DONE;
          end else begin
            st <= S_RD_DIR;
          end
        end
        S_RD_DIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          st <= S_CHK_DIR;
        end
        S_CHK_DIR: begin
          if (!pde_q[B_P]) begin
            if (dbg_q) phys_q <= 32'hFFFF_FFFF;
            else begin fault_q <= 1'b1; err_q <= {usr_q, wr_q, 1'b0}; end
            st <= S_DONE;
          end else if (!dbg_q && lg && perm_bad) begin
            fault_q <= 1'b1; err_q <= {usr_q, wr_q, 1'b1};
            st <= S_DONE;
          end else begin
            if (lg) phys_q <= big_phys;
            if (!dbg_q && dir_wb) begin
              pde_q <= dir_upd;
              st <= S_WB_DIR;
            end else begin
              st <= lg ? S_DONE : S_RD_TBL;
            end
          end
        end
        S_WB_DIR: if (mem_ack) st <= lg ? S_DONE : S_RD_TBL;
        S_RD_TBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          st <= S_CHK_TBL;
        end
        S_CHK_TBL: begin
          if (!pte_q[B_P]) begin
            if (dbg_q) phys_q <= 32'hFFFF_FFFF;
            else begin fault_q <= 1'b1; err_q <= {usr_q, wr_q, 1'b0}; end
            st <= S_DONE;
          end else if (!dbg_q && perm_bad) begin
            fault_q <= 1'b1; err_q <= {usr_q, wr_q, 1'b1};
            st <= S_DONE;
          end else begin
            phys_q <= small_phys;
            if (!dbg_q && tbl_wb) begin
              pte_q <= tbl_upd;
              st <= S_WB_TBL;
            end else begin
              st <= S_DONE;
            end
          end
        end
        S_WB_TBL: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_dbg_nowrite_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !dbg_q);
  p_dbg_nofault_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dbg_q) |-> !done_fault);
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pg_q) |-> (done_phys == lin_q && !done_fault));
  p_errcode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_err[2] == usr_q && done_err[1] == wr_q));
  p_wb_accessed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_A]);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_debug = 1'b0;
  logic cfg_paging = 1'b0, cfg_wp = 1'b0, cfg_large = 1'b0;
  logic [31:0] req_lin = '0, cfg_root = '0, cfg_a20 = '1;
  logic busy, done, done_fault, mem_req, mem_we;
  logic [2:0] done_err;
  logic [31:0] done_phys, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic [31:0] ref_mem [0:4095];
  logic [31:0] rd_addr [0:1];
  int rd_n = 0, wr_n = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] e_phys, e_rd0, e_rd1;
  logic e_fault;
  logic [2:0] e_err;
  int e_nrd, e_nwr;

  always #2 clk = ~clk;

  pt_walker dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .req_debug(req_debug),
    .cfg_paging(cfg_paging), .cfg_wp(cfg_wp), .cfg_large(cfg_large),
    .cfg_root(cfg_root), .cfg_a20(cfg_a20), .busy(busy), .done(done),
    .done_fault(done_fault), .done_err(done_err), .done_phys(done_phys),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_n = wr_n + 1;
      end else begin
        if (rd_n < 2) rd_addr[rd_n] = mem_addr;
        rd_n = rd_n + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_at(input logic [31:0] base, lin, a20);
    return ((base & ~32'hFFF) + ((lin >> 20) & ~32'h3)) & a20;
  endfunction
  function automatic logic [31:0] tbl_at(input logic [31:0] pde, lin, a20);
    return ((pde & ~32'hFFF) + ((lin >> 10) & 32'hFFC)) & a20;
  endfunction
  function automatic logic bad_perm(input logic eu, erw, u, w, wp);
    return u ? (!eu || (w && !erw)) : (wp && eu && w && !erw);
  endfunction

  task automatic poke(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[13:2]] = val;
    ref_mem[addr[13:2]] = val;
  endtask

  task automatic model(input logic [31:0] lin, input logic w, u, d, pg, wp, le,
                       input logic [31:0] base, a20);
    logic [31:0] pa, ta, pde, pte;
    e_fault = 0; e_err = 0; e_nrd = 0; e_nwr = 0; e_rd0 = 0; e_rd1 = 0; e_phys = 0;
    if (!pg) begin e_phys = lin; return; end
    pa = dir_at(base, lin, a20); e_rd0 = pa; e_nrd = 1;
    pde = ref_mem[pa[13:2]];
    if (!pde[0]) begin
      if (d) e_phys = '1; else begin e_fault = 1; e_err = {u, w, 1'b0}; end
      return;
    end
    if (pde[7] && le) begin
      if (!d) begin
        if (bad_perm(pde[2], pde[1], u, w, wp)) begin e_fault = 1; e_err = {u, w, 1'b1}; return; end
        if (!pde[5] || (w && !pde[6])) begin
          pde[5] = 1; if (w) pde[6] = 1;
          ref_mem[pa[13:2]] = pde; e_nwr = 1;
        end
      end
      e_phys = (pde & a20 & 32'hFFC0_0000) | (lin & 32'h003F_FFFF);
      return;
    end
    if (!d && !pde[5]) begin pde[5] = 1; ref_mem[pa[13:2]] = pde; e_nwr = 1; end
    ta = tbl_at(pde, lin, a20); e_rd1 = ta; e_nrd = 2;
    pte = ref_mem[ta[13:2]];
    if (!pte[0]) begin
      if (d) e_phys = '1; else begin e_fault = 1; e_err = {u, w, 1'b0}; end
      return;
    end
    if (!d) begin
      if (bad_perm(pte[2] & pde[2], pte[1] & pde[1], u, w, wp)) begin
        e_fault = 1; e_err = {u, w, 1'b1}; return;
      end
      if (!pte[5] || (w && !pte[6])) begin
        pte[5] = 1; if (w) pte[6] = 1;
        ref_mem[ta[13:2]] = pte; e_nwr = e_nwr + 1;
      end
    end
    e_phys = (pte & a20 & 32'hFFFF_F000) | (lin & 32'h0000_0FFF);
  endtask

  task automatic run(input logic [31:0] lin, input logic w, u, d, pg, wp, le,
                     input logic [31:0] base, a20, input bit extra);
    int t;
    model(lin, w, u, d, pg, wp, le, base, a20);
    @(negedge clk);
    req_lin = lin; req_write = w; req_user = u; req_debug = d;
    cfg_paging = pg; cfg_wp = wp; cfg_large = le; cfg_root = base; cfg_a20 = a20;
    rd_n = 0; wr_n = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", {31'd0, busy | done}, 32'd1);
    if (extra) begin
      req_valid = 1'b1; req_lin = ~lin; req_write = ~w; req_user = ~u;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 60) begin @(negedge clk); t++; end
    chk("R12 done reached", {31'd0, done}, 32'd1);
    chk("R11 fault flag", {31'd0, done_fault}, {31'd0, e_fault});
    if (e_fault) chk("R11 error code", {29'd0, done_err}, {29'd0, e_err});
    else chk(!pg ? "R1 passthrough" : "R10 physical address", done_phys, e_phys);
    chk("R9 write count", wr_n, e_nwr);
    chk("R2 read count", rd_n, e_nrd);
    if (e_nrd >= 1 && rd_n >= 1) chk("R2 directory address", rd_addr[0], e_rd0);
    if (e_nrd == 2 && rd_n == 2) chk("R3 table address", rd_addr[1], e_rd1);
    if (e_nrd >= 1) chk("R9 directory word", mem[e_rd0[13:2]], ref_mem[e_rd0[13:2]]);
    if (e_nrd == 2) chk("R9 table word", mem[e_rd1[13:2]], ref_mem[e_rd1[13:2]]);
    @(negedge clk);
    chk("R12 done one cycle", {31'd0, done}, 32'd0);
    chk("R12 idle after", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, lin, pa, pde, a20;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;

    // R1: paging off
    run(32'h1234_5678, 1, 1, 0, 0, 1, 1, 32'h1000, '1, 0);
    // R4 R9: large page write sets accessed and dirty
    base = 32'h1000; lin = 32'h0ABC_DEF0;
    poke(dir_at(base, lin, '1), 32'h8A40_0087);
    run(lin, 1, 1, 0, 1, 0, 1, base, '1, 0);
    // R9: entry already accessed and dirty, no write
    run(lin, 1, 1, 0, 1, 0, 1, base, '1, 0);
    // R4: size bit without large-page enable walks the table
    lin = 32'h0000_1234; pa = dir_at(base, lin, '1);
    poke(pa, 32'h0000_2087);
    poke(tbl_at(32'h0000_2087, lin, '1), 32'h5555_5007);
    run(lin, 0, 1, 0, 1, 0, 0, base, '1, 0);
    // R5 R6: directory user bit clear masks table user bit
    lin = 32'h0040_3000; pa = dir_at(base, lin, '1);
    poke(pa, 32'h0000_3003);
    poke(tbl_at(32'h0000_3003, lin, '1), 32'h7777_7007);
    run(lin, 0, 1, 0, 1, 0, 0, base, '1, 0);
    // R7: supervisor write to read-only user page
    poke(pa, 32'h0000_3005);
    run(lin, 1, 0, 0, 1, 1, 0, base, '1, 0);
    run(lin, 1, 0, 0, 1, 0, 0, base, '1, 0);
    // R8 R13: not-present in debug and normal
    lin = 32'h0080_0000; poke(dir_at(base, lin, '1), 32'h0000_0002);
    run(lin, 1, 1, 1, 1, 1, 1, base, '1, 0);
    run(lin, 1, 1, 0, 1, 1, 1, base, '1, 0);
    // R10: address-20 mask clears frame bit 20
    lin = 32'h0100_0ABC; a20 = 32'hFFEF_FFFF; pa = dir_at(base, lin, a20);
    poke(pa, 32'h0000_2067);
    poke(tbl_at(32'h0000_2067, lin, a20), 32'h0BF0_0067);
    run(lin, 0, 0, 0, 1, 0, 0, base, a20, 0);
    // R12: request during walk ignored
    run(lin, 0, 0, 0, 1, 0, 0, base, a20, 1);

    for (int k = 0; k < 400; k++) begin
      logic w, u, d, pg, wp, le;
      base = $urandom; lin = $urandom;
      a20 = ($urandom % 4 == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      w = 1'($urandom); u = 1'($urandom); wp = 1'($urandom); le = 1'($urandom);
      d = ($urandom % 6 == 0); pg = ($urandom % 10 != 0);
      pde = $urandom; if ($urandom % 8 != 0) pde[0] = 1'b1;
      pa = dir_at(base, lin, a20);
      poke(pa, pde);
      pde = $urandom; if ($urandom % 8 != 0) pde[0] = 1'b1;
      if ($urandom % 10 != 0) poke(tbl_at(mem[pa[13:2]], lin, a20), pde);
      run(lin, w, u, d, pg, wp, le, base, a20, k % 7 == 0 && pg);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule